// File: doc/BRIEF.md
# Forward 8x8 Integer Block Transform

This block takes an 8x8 block of pixels and their predictions as a stream of eight rows and returns the block's forward integer transform. Each pixel's prediction is subtracted from it to form a residual. A one-dimensional 8-point transform is applied to every residual row. The intermediate result is kept in transposed order, and a second pass of the same transform is run over it. The coefficient block then leaves as eight rows of eight signed 16-bit values.

Both passes split each 8-sample vector into four sums and four differences of mirrored samples. The even outputs are weighted from the sums and the odd outputs from the differences, using a fixed integer coefficient set. A rounded arithmetic shift follows: 2 bits after the first pass and 9 bits after the second pass for 8-bit pixels. A block is accepted whole. It is then moved through the second pass in eight cycles and emitted under valid/ready flow control before the next block is taken.

Top module: `dct8x8_core`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are both 0. After `rst_n` rises, `in_ready` is still 0 following the first rising clock edge and becomes 1 following the second.
- R2: Each pixel's residual is the unsigned source pixel minus the unsigned prediction pixel, taken as a signed value. Lane n of `in_src`/`in_pred` is bits [8n+7:8n] and is sample x[n] of its row. Rows are accepted in order, starting with row 0.
- R3: First pass: for each residual row, s_k = x[k]+x[7-k] and d_k = x[k]-x[7-k] for k = 0..3. The even outputs use the weights {64,64,64,64}, {83,36,-36,-83}, {64,-64,-64,64} and {36,-83,83,-36} on the s terms, for outputs 0, 2, 4 and 6. The odd outputs use {89,75,50,18}, {75,-18,-89,-50}, {50,-89,18,75} and {18,-50,75,-89} on the d terms, for outputs 1, 3, 5 and 7. Each output has 2 added and is then shifted right arithmetically by 2. Output k of input row i lands in column i of row k of the intermediate block.
- R4: Second pass: the same weights are applied to each intermediate row k, with 256 added and an arithmetic right shift of 9. Output j of that pass is final coefficient (j, k). Coefficient (j, k) appears on `out_coef` bits [16k+15:16k] of output row j. Each value is clamped to the signed 16-bit range.
- R5: `in_ready` is high only while fewer than eight rows of the current block have been accepted. It is never high together with `out_valid`.
- R6: `out_valid` first rises exactly 8 clock cycles after the edge that accepts a block's eighth row. It stays low during those cycles.
- R7: Output rows leave in coefficient-row order 0 to 7. `out_last` is 1 exactly on row 7.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_coef` and `out_last` hold their values.
- R9: No row is accepted while `in_valid` or `in_ready` is 0. Data offered then has no effect on any coefficient.
- R10: `in_ready` returns to 1 on the cycle after the last output row is taken, and the next block starts clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A row of source and prediction pixels is offered |
| in_ready | output | 1 | The block can accept a row |
| in_src | input | 64 | Eight source pixels, lane n at bits [8n+7:8n] |
| in_pred | input | 64 | Eight prediction pixels, same lane layout |
| out_valid | output | 1 | A coefficient row is presented |
| out_ready | input | 1 | The consumer takes the presented row |
| out_coef | output | 128 | Eight signed 16-bit coefficients, lane k at bits [16k+15:16k] |
| out_last | output | 1 | The presented row is the block's last |

## Verification
A row is written at the edge that accepts it. After the eighth accepting edge, eight second-pass cycles follow, so `out_valid` is due in the cycle after the eighth edge beyond the acceptance. `in_ready` is due one cycle after the last output handshake, and two edges after reset release. The bench's model advances its own accept count, cycle countdown and output row index at every edge. It compares both handshake outputs at each falling edge against those expectations. It compares a coefficient row only in a cycle in which its model predicts a handshake, which keeps each check on the cycle when its result is due.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int LANES  = 8;
  localparam int HALF   = LANES / 2;
  localparam int COEF_W = 16;
  localparam int ACC_W  = 32;

  // Weight for output row j applied to butterfly term k (k < HALF).
  // Even rows weight the mirrored sums, odd rows the mirrored differences.
  function automatic int half_weight(input int j, input int k);
    int w;
    w = 0;
    case (j)
      0: w = 64;
      1: case (k) 0: w = 89; 1: w = 75;  2: w = 50;  default: w = 18;  endcase
      2: case (k) 0: w = 83; 1: w = 36;  2: w = -36; default: w = -83; endcase
      3: case (k) 0: w = 75; 1: w = -18; 2: w = -89; default: w = -50; endcase
      4: case (k) 0: w = 64; 1: w = -64; 2: w = -64; default: w = 64;  endcase
      5: case (k) 0: w = 50; 1: w = -89; 2: w = 18;  default: w = 75;  endcase
      6: case (k) 0: w = 36; 1: w = -83; 2: w = 83;  default: w = -36; endcase
      default: case (k) 0: w = 18; 1: w = -50; 2: w = 75; default: w = -89; endcase
    endcase
    return w;
  endfunction

  function automatic logic signed [COEF_W-1:0] clamp16(input logic signed [ACC_W-1:0] v);
    if (v > 32'sd32767)       return 16'sh7fff;
    else if (v < -32'sd32768) return 16'sh8000;
    else                      return v[COEF_W-1:0];
  endfunction

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_XFER = 2'd1,
    ST_EMIT = 2'd2
  } phase_t;

endpackage

// File: rtl/dct8_row.sv
module dct8_row
  import dct8_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int SHIFT = 2
) (
  input  logic [LANES*IN_W-1:0]   x_flat,
  output logic [LANES*COEF_W-1:0] y_flat
);

  localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (SHIFT - 1);

  logic signed [ACC_W-1:0] xs [LANES];
  logic signed [ACC_W-1:0] sm [HALF];
  logic signed [ACC_W-1:0] df [HALF];
  logic signed [ACC_W-1:0] acc [LANES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_ext
      assign xs[gi] = ACC_W'(signed'(x_flat[gi*IN_W +: IN_W]));
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < HALF; k++) begin
      sm[k] = xs[k] + xs[LANES-1-k];
      df[k] = xs[k] - xs[LANES-1-k];
    end
    for (int j = 0; j < LANES; j++) begin
      acc[j] = ROUND;
      for (int k = 0; k < HALF; k++) begin
        if (j % 2 == 0) acc[j] = acc[j] + half_weight(j, k) * sm[k];
        else            acc[j] = acc[j] + half_weight(j, k) * df[k];
      end
    end
  end

  generate
    for (gi = 0; gi < LANES; gi++) begin : g_out
      assign y_flat[gi*COEF_W +: COEF_W] = clamp16(acc[gi] >>> SHIFT);
    end
  endgenerate

endmodule

// File: rtl/dct8_tbuf.sv
module dct8_tbuf
  import dct8_pkg::*;
#(
  parameter int W = COEF_W
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [2:0]           wr_col,
  input  logic [LANES*W-1:0]   wr_data,
  input  logic [2:0]           rd_row,
  output logic [LANES*W-1:0]   rd_data
);

  logic [W-1:0] mem [LANES][LANES];

  genvar gr, gc;
  generate
    for (gr = 0; gr < LANES; gr++) begin : g_row
      always_ff @(posedge clk) begin
        if (wr_en) mem[gr][wr_col] <= wr_data[gr*W +: W];
      end
    end
    for (gc = 0; gc < LANES; gc++) begin : g_rd
      assign rd_data[gc*W +: W] = mem[rd_row][gc];
    end
  endgenerate

endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
  import dct8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       out_ready,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_last,
  output logic       a_wr,
  output logic       b_wr,
  output logic [2:0] idx
);

  phase_t     st_q, st_d;
  logic [2:0] cnt_q, cnt_d;
  logic       cnt_en;

  assign idx       = cnt_q;
  assign in_ready  = rst_n && (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_EMIT);
  assign out_last  = (st_q == ST_EMIT) && (cnt_q == 3'd7);
  assign a_wr      = in_valid && in_ready;
  assign b_wr      = (st_q == ST_XFER);

  always_comb begin
    st_d   = st_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_LOAD: if (a_wr) begin
        cnt_en = 1'b1;
        if (cnt_q == 3'd7) st_d = ST_XFER;
      end
      ST_XFER: begin
        cnt_en = 1'b1;
        if (cnt_q == 3'd7) st_d = ST_EMIT;
      end
      ST_EMIT: if (out_ready) begin
        cnt_en = 1'b1;
        if (cnt_q == 3'd7) st_d = ST_LOAD;
      end
      default: st_d = ST_LOAD;
    endcase
    cnt_d = cnt_en ? cnt_q + 3'd1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      cnt_q <= 3'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dct8x8_core.sv
module dct8x8_core
  import dct8_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*PIX_W-1:0]  in_src,
  input  logic [LANES*PIX_W-1:0]  in_pred,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*COEF_W-1:0] out_coef,
  output logic                    out_last
);

  localparam int LOG2N = $clog2(LANES);
  localparam int RES_W = PIX_W + 1;
  localparam int SH1   = LOG2N + PIX_W - 9;
  localparam int SH2   = LOG2N + 6;

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [LANES*RES_W-1:0]  resid;
  logic [LANES*COEF_W-1:0] p1_out, a_row, p2_out;
  logic                    a_wr, b_wr;
  logic [2:0]              idx;

  genvar gn;
  generate
    for (gn = 0; gn < LANES; gn++) begin : g_res
      assign resid[gn*RES_W +: RES_W] =
        {1'b0, in_src[gn*PIX_W +: PIX_W]} - {1'b0, in_pred[gn*PIX_W +: PIX_W]};
    end
  endgenerate

  dct8_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .a_wr      (a_wr),
    .b_wr      (b_wr),
    .idx       (idx)
  );

  dct8_row #(.IN_W(RES_W), .SHIFT(SH1)) u_pass1 (
    .x_flat (resid),
    .y_flat (p1_out)
  );

  dct8_tbuf #(.W(COEF_W)) u_buf_a (
    .clk     (clk),
    .wr_en   (a_wr),
    .wr_col  (idx),
    .wr_data (p1_out),
    .rd_row  (idx),
    .rd_data (a_row)
  );

  dct8_row #(.IN_W(COEF_W), .SHIFT(SH2)) u_pass2 (
    .x_flat (a_row),
    .y_flat (p2_out)
  );

  dct8_tbuf #(.W(COEF_W)) u_buf_b (
    .clk     (clk),
    .wr_en   (b_wr),
    .wr_col  (idx),
    .wr_data (p2_out),
    .rd_row  (idx),
    .rd_data (out_coef)
  );

endmodule

// File: rtl/dct8_checker.sv
module dct8_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_coef,
  input logic         out_last
);

  logic [2:0] n_acc;
  logic [3:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_acc <= 3'd0;
      gap   <= 4'd0;
    end else begin
      if (in_valid && in_ready) n_acc <= n_acc + 3'd1;
      if (in_valid && in_ready && n_acc == 3'd7) gap <= 4'd1;
      else if (gap == 4'd8)                      gap <= 4'd0;
      else if (gap != 4'd0)                      gap <= gap + 4'd1;
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (!in_ready && !out_valid));

  p_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != 4'd0) |-> (!out_valid && !in_ready));

  p_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == 4'd8) |=> out_valid);

  p_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_last)));

  p_reopen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

endmodule

bind dct8x8_core dct8_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .out_last  (out_last)
);

// File: tb/sim_dct8x8_core.sv
`timescale 1ns/1ps
module sim_dct8x8_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_src = '0;
  logic [63:0]  in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_coef;
  logic         out_last;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dct8x8_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_coef(out_coef), .out_last(out_last)
  );

  int wt [8][8];
  int src_m [8][8];
  int pred_m [8][8];
  int expf [8][8];

  // model state
  int m_rows = 0;
  int m_rem  = 0;
  bit m_emit = 0;
  int m_orow = 0;
  bit stall_prev = 0;
  logic [127:0] prev_coef;
  logic         prev_last;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rshift_rnd(input int v, input int sh);
    return (v + (1 << (sh - 1))) >>> sh;
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic build_weights();
    int h [8][4];
    h[0] = '{64, 64, 64, 64};   h[1] = '{89, 75, 50, 18};
    h[2] = '{83, 36, -36, -83}; h[3] = '{75, -18, -89, -50};
    h[4] = '{64, -64, -64, 64}; h[5] = '{50, -89, 18, 75};
    h[6] = '{36, -83, 83, -36}; h[7] = '{18, -50, 75, -89};
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++)
        wt[j][i] = (i < 4) ? h[j][i] : ((j % 2 == 0) ? h[j][7-i] : -h[j][7-i]);
  endtask

  task automatic compute_expected();
    int a [8][8];
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 8; k++) begin
        int s = 0;
        for (int n = 0; n < 8; n++) s += wt[k][n] * (src_m[i][n] - pred_m[i][n]);
        a[i][k] = sat16(rshift_rnd(s, 2));
      end
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) begin
        int s = 0;
        for (int i = 0; i < 8; i++) s += wt[j][i] * a[i][k];
        expf[j][k] = sat16(rshift_rnd(s, 9));
      end
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < 8; i++)
      for (int n = 0; n < 8; n++) begin
        case (mode)
          1: begin src_m[i][n] = 255; pred_m[i][n] = 0; end
          2: begin src_m[i][n] = 0;   pred_m[i][n] = 255; end
          3: begin src_m[i][n] = ((i + n) % 2) ? 255 : 0; pred_m[i][n] = ((i + n) % 2) ? 0 : 255; end
          4: begin src_m[i][n] = int'($urandom % 256); pred_m[i][n] = src_m[i][n]; end
          5: begin src_m[i][n] = (i * 8 + n) * 4; pred_m[i][n] = 128; end
          default: begin src_m[i][n] = int'($urandom % 256); pred_m[i][n] = int'($urandom % 256); end
        endcase
      end
  endtask

  task automatic run_block(input int mode, input int vden, input int rden, input string tag);
    bit done = 0;
    fill(mode);
    compute_expected();
    while (!done) begin
      bit exp_rdy, acc, take;
      @(negedge clk);
      exp_rdy = (m_rows < 8) && (m_rem == 0) && !m_emit;
      chk(out_valid == m_emit, "R6", out_valid, m_emit);
      chk(in_ready == exp_rdy, "R5", in_ready, exp_rdy);
      if (stall_prev) begin
        chk(out_coef == prev_coef, "R8", 0, 0);
        chk(out_last == prev_last, "R8", out_last, prev_last);
      end
      if (exp_rdy) begin
        in_valid = (($urandom % 100) < vden);
        for (int n = 0; n < 8; n++) begin
          in_src[n*8 +: 8]  = 8'(src_m[m_rows][n]);
          in_pred[n*8 +: 8] = 8'(pred_m[m_rows][n]);
        end
      end else begin
        // R9: rows offered while the block is not ready must be ignored
        in_valid = $urandom % 2;
        in_src   = {$urandom, $urandom};
        in_pred  = {$urandom, $urandom};
      end
      out_ready = (($urandom % 100) < rden);
      acc  = in_valid && exp_rdy;
      take = out_ready && m_emit;
      stall_prev = m_emit && !out_ready;
      prev_coef  = out_coef;
      prev_last  = out_last;
      if (take) begin
        for (int k = 0; k < 8; k++) begin
          int act = int'(signed'(out_coef[k*16 +: 16]));
          chk(act == expf[m_orow][k], tag, act, expf[m_orow][k]);
        end
        chk(out_last == (m_orow == 7), "R7", out_last, m_orow == 7);
        m_orow++;
        if (m_orow == 8) begin
          m_emit = 0;
          m_rows = 0;
          done = 1;
        end
      end
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) begin
          m_emit = 1;
          m_orow = 0;
        end
      end
      if (acc) begin
        m_rows++;
        if (m_rows == 8) m_rem = 8;
      end
    end
  endtask

  initial begin
    build_weights();
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    // back-to-back blocks; R10 checked at each block boundary by the model
    run_block(1, 100, 100, "R2");
    run_block(2, 100, 100, "R2");
    run_block(3, 100, 100, "R3");
    run_block(4, 70, 50, "R2");
    run_block(5, 100, 30, "R3");
    for (int b = 0; b < 6; b++) run_block(0, 60, 40, "R4");
    run_block(0, 30, 80, "R9");
    run_block(0, 100, 100, "R10");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule